// File: doc/BRIEF.md
# Block-Counted DMA Channel with Halfword FIFO

This block is one DMA channel that moves 16-bit data between a peripheral FIFO port and system memory. It moves data only in whole 64-byte blocks, each 32 halfwords. It counts blocks, not bytes. A halfword FIFO that holds exactly one block sits between the peripheral side and a request/acknowledge burst interface on the memory side. Each memory burst is 32 beats, one halfword per acknowledged beat.

Software controls the channel through a small register port. The mode/status word holds the direction, enable and interrupt enable, the FIFO fill level, the FIFO-empty, interrupt-pending and error flags, and two self-clearing strobes: FIFO clear and error clear. The load address register drops its low six bits. The current-address register shows where the block in progress sits in memory. The 16-bit block count register starts and stops the channel.

Software can chain segments. It writes a new load address and then a nonzero block count while the channel stays enabled. A FIFO data port lets software push or pop halfwords directly. It uses this to prime a partial first block or to pad out a partial last block.

Top module: `blk_dma_chan`

Register index (`reg_addr_i`): 0 mode/status, 1 load address, 2 current address, 3 block count, 4 FIFO data.

## Requirements
- R1: After reset the mode/status word reads 0x20 (FIFO empty, nothing else set), the block count and current address read 0, and `mem_req_o` and `irq_o` are low.
- R2: The load address (index 1) reads back with bits [5:0] forced to zero and all higher bits as written.
- R3: The channel runs when it is enabled, the block count is nonzero and the direction bit (mode bit 8) is 1 (peripheral to memory). In that state it raises `mem_req_o` with `mem_we_o` high once the FIFO holds 32 halfwords. It then writes them in FIFO order, beat k at current address + 2k.
- R4: The channel also runs when it is enabled with a nonzero block count and direction 0 (memory to peripheral). In that state it starts a 32-beat read burst when the FIFO is empty. It delivers the fetched halfwords to the peripheral pop port in address order.
- R5: Each completed block adds 64 to the current address and subtracts 1 from the block count. The channel issues no further burst once the count reaches zero.
- R6: When the count reaches zero by block completion and interrupt enable (mode bit 10) is set, interrupt-pending (status bit 6) and `irq_o` go high. With interrupt enable clear they stay low.
- R7: Writing a nonzero block count clears interrupt-pending and loads the current address from the load address. An enabled channel then resumes from the new address.
- R8: Writing block count zero, or writing the mode word with enable (bit 9) clear, drops `mem_req_o` on the next cycle, even mid-burst. Interrupt-pending keeps its value.
- R9: A write to the direction bit is ignored while enable is set.
- R10: Status bits [4:0] give the FIFO fill level modulo 32. Bit 5 is set only when the FIFO is empty.
- R11: Software writes to index 4 push the low halfword into the FIFO. Reads of index 4 return the oldest halfword and pop it.
- R12: Writing mode bit 11 empties the FIFO. A software push to a full FIFO, a pop from an empty one, or any index-4 access during a burst sets the error flag (status bit 7). Writing mode bit 12 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops FIFO at index 4) |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | AW | Register write data |
| reg_rdata_o | output | AW | Register read data (combinational) |
| per_push_i | input | 1 | Peripheral pushes a halfword (peripheral to memory) |
| per_pdata_i | input | DW | Peripheral push data |
| per_space_o | output | 1 | FIFO accepts a peripheral push this cycle |
| per_pop_i | input | 1 | Peripheral takes a halfword (memory to peripheral) |
| per_data_o | output | DW | FIFO head toward the peripheral |
| per_avail_o | output | 1 | FIFO offers a halfword to the peripheral this cycle |
| mem_req_o | output | 1 | Burst in progress; each beat waits for acknowledge |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | AW | Byte address of the current beat |
| mem_wdata_o | output | DW | Write data of the current beat |
| mem_rdata_i | input | DW | Read data of the current beat |
| mem_ack_i | input | 1 | Beat acknowledge |
| irq_o | output | 1 | Interrupt pending |

## Verification
A burst counter that slips shows up at the memory port within one block: halfwords land at shifted addresses, or the current address ends off a 64-byte multiple. A wrong block count or a lost terminal count shows in the current-address readback and in `irq_o` as soon as the final block completes. A FIFO pointer or level fault shows in status bits [5:0] on the next register read, and in the order of halfwords at the peripheral pop port. A stop that fails to abort leaves `mem_req_o` high one cycle after the write.

// File: rtl/blk_dma_pkg.sv
`timescale 1ns/1ps
package blk_dma_pkg;
  typedef enum logic [2:0] {
    RA_MODE = 3'd0,
    RA_LOAD = 3'd1,
    RA_CUR  = 3'd2,
    RA_BCNT = 3'd3,
    RA_FIFO = 3'd4
  } reg_idx_e;

  localparam int SB_EMPTY = 5;
  localparam int SB_PEND  = 6;
  localparam int SB_ERR   = 7;
  localparam int MB_DIR   = 8;
  localparam int MB_EN    = 9;
  localparam int MB_IE    = 10;
  localparam int MB_CLR   = 11;
  localparam int MB_ECLR  = 12;
endpackage

// File: rtl/dma_hw_fifo.sv
`timescale 1ns/1ps
module dma_hw_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i && !clr_i) mem_q[wp_q] <= pdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      if (push_i && !pop_i)      lvl_q <= lvl_q + 1'b1;
      else if (pop_i && !push_i) lvl_q <= lvl_q - 1'b1;
    end
  end

  assign head_o  = mem_q[rp_q];
  assign level_o = lvl_q;
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign empty_o = (lvl_q == '0);

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !clr_i) |-> pop_i);
  p_no_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clr_i) |-> !empty_o);
endmodule

// File: rtl/dma_burst_ctl.sv
`timescale 1ns/1ps
module dma_burst_ctl #(
  parameter int BEATS = 32,
  localparam int BW   = $clog2(BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          ack_i,
  output logic          busy_o,
  output logic [BW-1:0] beat_o,
  output logic          beat_ok_o,
  output logic          done_o
);
  logic          busy_q;
  logic [BW-1:0] beat_q;
  logic          last;

  assign last      = (beat_q == BW'(BEATS - 1));
  assign beat_ok_o = busy_q && ack_i && !abort_i;
  assign done_o    = beat_ok_o && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (!busy_q) begin
      if (start_i) busy_q <= 1'b1;
      beat_q <= '0;
    end else if (ack_i) begin
      if (last) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;

  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ack_i && !abort_i) |=> (busy_q && $stable(beat_q)));
  p_beat_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ack_i && !abort_i && !last) |=> (beat_q == $past(beat_q) + 1'b1));
endmodule

// File: rtl/blk_dma_chan.sv
`timescale 1ns/1ps
module blk_dma_chan
  import blk_dma_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 16,
  parameter int BLK_BYTES = 64,
  parameter int CNT_W     = 16,
  localparam int HW_BLK   = BLK_BYTES / (DW / 8),
  localparam int OFS_W    = $clog2(BLK_BYTES),
  localparam int LW       = $clog2(HW_BLK + 1),
  localparam int BW       = $clog2(HW_BLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic [AW-1:0] reg_rdata_o,
  input  logic          per_push_i,
  input  logic [DW-1:0] per_pdata_i,
  output logic          per_space_o,
  input  logic          per_pop_i,
  output logic [DW-1:0] per_data_o,
  output logic          per_avail_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          irq_o
);
  logic             dir_q, en_q, ie_q, pend_q, err_q;
  logic [AW-1:0]    load_q, cur_q;
  logic [CNT_W-1:0] bcnt_q;

  logic          f_push, f_pop, f_full, f_empty;
  logic [DW-1:0] f_pdata, f_head;
  logic [LW-1:0] f_level;
  logic          busy, beat_ok, blk_done;
  logic [BW-1:0] beat;

  reg_idx_e ridx;
  assign ridx = reg_idx_e'(reg_addr_i);

  logic mode_wr, clr_wr, eclr_wr, bcnt_wr, load_wr;
  logic sw_acc, sw_push, sw_pop, err_set, running, abort, start;

  assign mode_wr = reg_we_i && ridx == RA_MODE;
  assign clr_wr  = mode_wr && reg_wdata_i[MB_CLR];
  assign eclr_wr = mode_wr && reg_wdata_i[MB_ECLR];
  assign bcnt_wr = reg_we_i && ridx == RA_BCNT;
  assign load_wr = reg_we_i && ridx == RA_LOAD;

  // software FIFO port: locked out while the memory side owns the FIFO
  assign sw_acc  = (reg_we_i || reg_re_i) && ridx == RA_FIFO;
  assign sw_push = sw_acc && reg_we_i && !busy && !f_full;
  assign sw_pop  = sw_acc && reg_re_i && !reg_we_i && !busy && !f_empty;
  assign err_set = sw_acc && (busy || (reg_we_i && f_full) ||
                              (reg_re_i && !reg_we_i && f_empty));

  assign running = en_q && (bcnt_q != '0);
  assign abort   = !running || bcnt_wr || clr_wr || (mode_wr && !reg_wdata_i[MB_EN]);
  assign start   = running && (dir_q ? f_full : f_empty);

  assign per_space_o = dir_q && !f_full && !sw_acc;
  assign per_avail_o = !dir_q && !f_empty && !sw_acc;

  assign f_push  = sw_push || (dir_q ? (per_push_i && per_space_o) : beat_ok);
  assign f_pop   = sw_pop || (dir_q ? beat_ok : (per_pop_i && per_avail_o));
  assign f_pdata = sw_push ? reg_wdata_i[DW-1:0] : (dir_q ? per_pdata_i : mem_rdata_i);

  dma_hw_fifo #(.DW(DW), .DEPTH(HW_BLK)) i_fifo (
    .clk_i, .rst_ni,
    .clr_i  (clr_wr),
    .push_i (f_push),
    .pdata_i(f_pdata),
    .pop_i  (f_pop),
    .head_o (f_head),
    .level_o(f_level),
    .full_o (f_full),
    .empty_o(f_empty)
  );

  dma_burst_ctl #(.BEATS(HW_BLK)) i_burst (
    .clk_i, .rst_ni,
    .start_i  (start),
    .abort_i  (abort),
    .ack_i    (mem_ack_i),
    .busy_o   (busy),
    .beat_o   (beat),
    .beat_ok_o(beat_ok),
    .done_o   (blk_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
      err_q  <= 1'b0;
      load_q <= '0;
      cur_q  <= '0;
      bcnt_q <= '0;
    end else begin
      if (mode_wr) begin
        en_q <= reg_wdata_i[MB_EN];
        ie_q <= reg_wdata_i[MB_IE];
        if (!en_q) dir_q <= reg_wdata_i[MB_DIR];
      end
      if (err_set)      err_q <= 1'b1;
      else if (eclr_wr) err_q <= 1'b0;
      if (load_wr) load_q <= {reg_wdata_i[AW-1:OFS_W], {OFS_W{1'b0}}};
      if (bcnt_wr) begin
        bcnt_q <= reg_wdata_i[CNT_W-1:0];
        if (reg_wdata_i[CNT_W-1:0] != '0) begin
          cur_q  <= load_q;
          pend_q <= 1'b0;
        end
      end else if (blk_done) begin
        bcnt_q <= bcnt_q - 1'b1;
        cur_q  <= cur_q + AW'(BLK_BYTES);
        if (bcnt_q == CNT_W'(1) && ie_q) pend_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (ridx)
      RA_MODE: begin
        reg_rdata_o[LW-2:0]   = f_level[LW-2:0];
        reg_rdata_o[SB_EMPTY] = f_empty;
        reg_rdata_o[SB_PEND]  = pend_q;
        reg_rdata_o[SB_ERR]   = err_q;
        reg_rdata_o[MB_DIR]   = dir_q;
        reg_rdata_o[MB_EN]    = en_q;
        reg_rdata_o[MB_IE]    = ie_q;
      end
      RA_LOAD: reg_rdata_o = load_q;
      RA_CUR:  reg_rdata_o = cur_q;
      RA_BCNT: reg_rdata_o = AW'(bcnt_q);
      RA_FIFO: reg_rdata_o = AW'(f_head);
      default: reg_rdata_o = '0;
    endcase
  end

  assign per_data_o  = f_head;
  assign mem_wdata_o = f_head;
  assign mem_req_o   = busy;
  assign mem_we_o    = dir_q;
  assign mem_addr_o  = cur_q | AW'({beat, 1'b0});
  assign irq_o       = pend_q;

  p_pend_at_tc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> (bcnt_q == '0));
  p_idle_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bcnt_q == '0) |-> !mem_req_o);
  p_idle_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !mem_req_o);
  p_dir_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> $stable(dir_q));
endmodule

// File: tb/test_blk_dma_chan.sv
`timescale 1ns/1ps
module test_blk_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        per_push = 1'b0, per_pop = 1'b0;
  logic [15:0] per_pdata = '0, per_data;
  logic        per_space, per_avail;
  logic        mem_req, mem_we, mem_ack, irq;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        ack_gate = 1'b1;
  logic        ack_tog = 1'b0;
  logic [15:0] mem_arr [256];

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  blk_dma_chan i_blk_dma_chan (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .per_push_i(per_push), .per_pdata_i(per_pdata), .per_space_o(per_space),
    .per_pop_i(per_pop), .per_data_o(per_data), .per_avail_o(per_avail),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .irq_o(irq)
  );

  // memory model: acknowledges every other cycle, read data derived from address
  always @(negedge clk) ack_tog <= ~ack_tog;
  assign mem_ack   = mem_req & ack_gate & ack_tog;
  assign mem_rdata = 16'h3000 + 16'(mem_addr[8:1]) * 16'd3;
  always @(posedge clk) if (mem_req && mem_we && mem_ack) mem_arr[mem_addr[8:1]] <= mem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, input bit pop = 0);
    @(negedge clk); reg_addr = a; reg_re = pop; #1 d = reg_rdata;
    @(negedge clk); reg_re = 1'b0;
  endtask

  task automatic push_n(input logic [15:0] base, input int n);
    int i = 0;
    while (i < n) begin
      @(negedge clk);
      if (per_space) begin per_push = 1'b1; per_pdata = base + 16'(i); i++; end
      else per_push = 1'b0;
    end
    @(negedge clk); per_push = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int k = 0; k < 400 && mem_req; k++) @(negedge clk);
  endtask

  typedef struct packed { logic [31:0] wv; logic [31:0] ev; } vec_t;
  localparam vec_t LOAD_VEC [4] = '{
    '{32'h0000_1234, 32'h0000_1200},
    '{32'hFFFF_FFFF, 32'hFFFF_FFC0},
    '{32'h0000_0040, 32'h0000_0040},
    '{32'h8000_003F, 32'h8000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, d); check("R1 status", d, 32'h20);
    rd(3, d); check("R1 bcnt", d, 0);
    rd(2, d); check("R1 cur", d, 0);
    check("R1 req/irq", {mem_req, irq}, 0);

    // R2 address alignment, table driven
    foreach (LOAD_VEC[i]) begin
      wr(1, LOAD_VEC[i].wv);
      rd(1, d); check("R2 load align", d, LOAD_VEC[i].ev);
    end

    // R3/R5/R6 peripheral to memory, two blocks at 0x40
    wr(0, 32'h500);
    wr(1, 32'h40);
    wr(0, 32'h700);
    wr(0, 32'h600);
    rd(0, d); check("R9 dir locked", d, 32'h720);
    wr(3, 2);
    push_n(16'h1000, 64);
    wait_idle();
    for (int i = 0; i < 64; i++) check("R3 mem data", 32'(mem_arr[8'h20 + i]), 32'(16'h1000 + i));
    rd(2, d); check("R5 cur after 2 blocks", d, 32'hC0);
    rd(3, d); check("R5 bcnt zero", d, 0);
    check("R6 irq at tc", 32'(irq), 1);
    rd(0, d); check("R6 pend status", d, 32'h760);

    // R7 chaining
    wr(1, 32'h100);
    wr(3, 1);
    check("R7 pend cleared", 32'(irq), 0);
    rd(2, d); check("R7 cur loaded", d, 32'h100);
    push_n(16'h2000, 32);
    wait_idle();
    for (int i = 0; i < 32; i++) check("R7 chained data", 32'(mem_arr[8'h80 + i]), 32'(16'h2000 + i));
    rd(2, d); check("R7 cur advanced", d, 32'h140);
    check("R7 pend again", 32'(irq), 1);

    // R8 disable keeps pending
    wr(0, 32'h500);
    check("R8 pend kept", 32'(irq), 1);

    // R8 stop mid burst by zero count
    wr(0, 32'h700);
    wr(1, 32'h1C0);
    ack_gate = 1'b0;
    wr(3, 1);
    push_n(16'h4000, 32);
    repeat (2) @(negedge clk);
    check("R3 burst starts when full", 32'(mem_req), 1);
    wr(3, 0);
    check("R8 stopped", 32'(mem_req), 0);
    rd(0, d); check("R10 full level", d, 32'h700);
    ack_gate = 1'b1;
    repeat (5) @(negedge clk);
    check("R8 stays stopped", 32'(mem_req), 0);

    // R12 fifo clear, then R4 memory to peripheral
    wr(0, 32'h800);
    rd(0, d); check("R12 fifo cleared", d, 32'h120);
    wr(0, 32'h000);
    wr(0, 32'h200);
    wr(1, 32'h180);
    wr(3, 1);
    begin
      int i = 0;
      while (i < 32) begin
        @(negedge clk);
        if (per_avail) begin
          check("R4 periph data", 32'(per_data), 32'(16'h3000 + 16'(8'hC0 + i) * 16'd3));
          per_pop = 1'b1; i++;
        end else per_pop = 1'b0;
      end
      @(negedge clk); per_pop = 1'b0;
    end
    wait_idle();
    check("R6 no irq when disabled", 32'(irq), 0);
    rd(2, d); check("R5 cur m2p", d, 32'h1C0);
    rd(0, d); check("R5 idle status", d, 32'h220);

    // R11/R10/R12 software FIFO port
    wr(0, 32'h000);
    wr(4, 32'hAAAA);
    wr(4, 32'hBBBB);
    wr(4, 32'hCCCC);
    rd(0, d); check("R10 level 3", d, 32'h003);
    rd(4, d, 1); check("R11 sw pop order", d, 32'hAAAA);
    rd(0, d); check("R11 level after pop", d, 32'h002);
    rd(4, d, 1); rd(4, d, 1); check("R11 last pop", d, 32'hCCCC);
    rd(4, d, 1);
    rd(0, d); check("R12 underflow err", d, 32'hA0);
    wr(0, 32'h1000);
    rd(0, d); check("R12 err cleared", d, 32'h20);
    for (int i = 0; i < 33; i++) wr(4, 32'(i));
    rd(0, d); check("R12 overflow err", d, 32'h80);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule